// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming network frames into host-supplied buffers that are described by a circular ring of receive descriptors. The descriptors sit in a small local memory. The host reads and writes that memory through a simple word port. Each descriptor carries the buffer base address, the buffer size and a status word, and a single ownership bit decides who may touch the descriptor. The host arms a descriptor by setting ownership to the engine. The engine fills the buffer with the next frame, writes back the byte count and a status summary, and then clears the ownership bit so the host can take the frame.

Frames arrive as a byte stream with a valid strobe, an end-of-frame marker and three error flags: CRC, framing and FIFO. There is no back-pressure. While idle, the engine keeps re-reading the current descriptor, so it can decide on the very first byte whether to accept or drop the frame. Accepted bytes go out on a registered byte-write port as base address plus offset. Bytes beyond the buffer size are discarded and the condition is reported. A frame that finds the current descriptor still held by the host is dropped and counted.

Top module: `rxr_top`

## Requirements
- R1: After a synchronous reset, `miss_count` is 0, `buf_we` is low, and the first accepted frame uses descriptor 0.
- R2: When the current descriptor has status bit 15 (ownership) set at the first byte of a frame, frame byte k is written to address base+k. `buf_we` is high in the cycle after that byte is presented, and the bytes keep their arrival order.
- R3: On an accepted frame, word 4i+2 is written first. Word 4i+1 is written the following cycle. In word 4i+1, status bit 15 is cleared, the low status byte is 0 and the length half is left unchanged. A clean frame leaves status high byte 0x03, where bit 9 marks start of packet and bit 8 marks end of packet.
- R4: Descriptor word 4i+2 holds the received byte count, including the 4 FCS bytes, in its low 12 bits, and its upper bits are 0.
- R5: The buffer size is the two's-complement negation of the 16-bit length field. For a frame longer than the buffer, only the first size bytes are written, status bit 12 (0x10 in the high byte) is set, the full count is still reported, and the descriptor is still returned.
- R6: An error flag seen on any byte of an accepted frame sets a status bit: CRC sets bit 11 (0x08 in the high byte), framing sets bit 13 (0x20) and FIFO sets bit 10 (0x04).
- R7: If status bit 15 of the current descriptor is clear when a frame starts, the whole frame is dropped. The drop makes no buffer write and no descriptor write, `miss_count` increases by 1, and the ring position does not move.
- R8: After each accepted frame the ring position advances by one, and after entry 2^LOG_RING-1 it wraps to 0.
- R9: Host word address 4i+0 holds the buffer base, 4i+1 holds {status, length} with the length in bits 15:0, and 4i+2 holds the message length. The engine never writes words 4i+0 and 4i+3. A host read returns data one cycle after the address is presented.
- R10: Frames separated by at least 5 idle cycles are each handled completely. A descriptor that the host re-arms is used again when the ring returns to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_crc_err | input | 1 | CRC error flag |
| in_frame_err | input | 1 | Framing error flag |
| in_fifo_err | input | 1 | FIFO error flag |
| host_we | input | 1 | Host descriptor write enable |
| host_addr | input | LOG_RING+2 | Host descriptor word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| miss_count | output | MISS_W | Dropped-frame counter, wraps |

## Verification
A wrong ring position shows up at the host port about two cycles after a frame's last byte: the status and length land in the wrong descriptor. A wrong size or overflow state shows up one cycle after the offending byte, as an extra or a missing write on the buffer port. A stale ownership snapshot turns into a `miss_count` step or a missing drop in the cycle after the frame's first byte. Error-flag accumulation, by contrast, stays hidden until the status word is read back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_POLL,
    ST_RECV,
    ST_DROP,
    ST_WB_LEN,
    ST_WB_STAT
  } rxr_state_e;

  // word offsets inside one 4-word descriptor
  localparam logic [1:0] W_BASE = 2'd0;
  localparam logic [1:0] W_CTRL = 2'd1;
  localparam logic [1:0] W_MLEN = 2'd2;

  // bit positions inside the 16-bit status half of the control word
  localparam int OWN_BIT  = 15;
  localparam int FRAM_BIT = 13;
  localparam int OFLO_BIT = 12;
  localparam int CRC_BIT  = 11;
  localparam int FIFO_BIT = 10;
  localparam int SOP_BIT  = 9;
  localparam int EOP_BIT  = 8;

  localparam int DESC_DW = 32;

  function automatic logic [15:0] neg16(input logic [15:0] v);
    return ~v + 16'd1;
  endfunction

endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // engine port is written after the host port: it wins on the same word
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/rxr_byte_store.sv
module rxr_byte_store #(
  parameter int BA_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [BA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       data_i,
  output logic             buf_we_o,
  output logic [BA_W-1:0]  buf_addr_o,
  output logic [7:0]       buf_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we_o <= 1'b0;
    end else begin
      buf_we_o <= req_i;
    end
    buf_addr_o <= base_i + BA_W'(off_i);
    buf_data_o <= data_i;
  end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int LOG_RING = 2,
  parameter int MISS_W   = 8,
  parameter int MLEN_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_last,
  input  logic                  in_crc_err,
  input  logic                  in_frame_err,
  input  logic                  in_fifo_err,
  output logic                  b_we_o,
  output logic [LOG_RING+1:0]   b_addr_o,
  output logic [DESC_DW-1:0]    b_wdata_o,
  input  logic [DESC_DW-1:0]    b_rdata_i,
  output logic                  st_req_o,
  output logic [DESC_DW-1:0]    st_base_o,
  output logic [15:0]           st_off_o,
  output logic [7:0]            st_data_o,
  output logic [MISS_W-1:0]     miss_o
);
  localparam logic [15:0] MLEN_MAX = 16'((1 << MLEN_W) - 1);
  localparam logic [LOG_RING-1:0] IDX_ONE = LOG_RING'(1);
  localparam logic [MISS_W-1:0]   MISS_ONE = MISS_W'(1);

  rxr_state_e state_q;
  logic [LOG_RING-1:0] idx_q;
  logic        phase_q, rd_vld_q, rd_sel_q;
  logic        got_base_q, got_ctrl_q;
  logic [31:0] snap_base_q;
  logic [15:0] snap_len_q;
  logic        snap_own_q;
  logic [31:0] base_q;
  logic [15:0] size_q, len_q, cnt_q;
  logic        oflo_q, crc_q, fram_q, fifo_q;
  logic [MISS_W-1:0] miss_q;

  logic        start, accept, take, fits;
  logic [31:0] cur_base;
  logic [15:0] cur_size, cur_cnt, cnt_inc;
  logic [7:0]  stat_hi;
  logic [31:0] mlen_word;

  assign start  = (state_q == ST_POLL) && in_valid;
  assign accept = start && got_base_q && got_ctrl_q && snap_own_q;
  assign take   = accept || ((state_q == ST_RECV) && in_valid);

  assign cur_base = accept ? snap_base_q : base_q;
  assign cur_size = accept ? neg16(snap_len_q) : size_q;
  assign cur_cnt  = accept ? 16'd0 : cnt_q;
  assign fits     = cur_cnt < cur_size;
  assign cnt_inc  = (cur_cnt == 16'hFFFF) ? cur_cnt : cur_cnt + 16'd1;

  assign st_req_o  = take && fits;
  assign st_base_o = cur_base;
  assign st_off_o  = cur_cnt;
  assign st_data_o = in_data;
  assign miss_o    = miss_q;

  always_comb begin
    stat_hi = 8'h00;
    stat_hi[FRAM_BIT-8] = fram_q;
    stat_hi[OFLO_BIT-8] = oflo_q;
    stat_hi[CRC_BIT-8]  = crc_q;
    stat_hi[FIFO_BIT-8] = fifo_q;
    stat_hi[SOP_BIT-8]  = 1'b1;
    stat_hi[EOP_BIT-8]  = 1'b1;
    mlen_word = (cnt_q > MLEN_MAX) ? 32'(MLEN_MAX) : 32'(cnt_q);
  end

  // descriptor port: poll base/control words while idle, write back after a frame
  always_comb begin
    b_we_o    = 1'b0;
    b_addr_o  = {idx_q, (phase_q ? W_CTRL : W_BASE)};
    b_wdata_o = '0;
    if (state_q == ST_WB_LEN) begin
      b_we_o    = 1'b1;
      b_addr_o  = {idx_q, W_MLEN};
      b_wdata_o = mlen_word;
    end else if (state_q == ST_WB_STAT) begin
      b_we_o    = 1'b1;
      b_addr_o  = {idx_q, W_CTRL};
      b_wdata_o = {stat_hi, 8'h00, len_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_POLL;
      idx_q      <= '0;
      phase_q    <= 1'b0;
      rd_vld_q   <= 1'b0;
      rd_sel_q   <= 1'b0;
      got_base_q <= 1'b0;
      got_ctrl_q <= 1'b0;
      snap_base_q <= '0;
      snap_len_q <= '0;
      snap_own_q <= 1'b0;
      base_q     <= '0;
      size_q     <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      oflo_q     <= 1'b0;
      crc_q      <= 1'b0;
      fram_q     <= 1'b0;
      fifo_q     <= 1'b0;
      miss_q     <= '0;
    end else begin
      rd_vld_q <= (state_q == ST_POLL);
      rd_sel_q <= phase_q;
      phase_q  <= (state_q == ST_POLL) ? ~phase_q : 1'b0;

      if (rd_vld_q && (state_q == ST_POLL)) begin
        if (rd_sel_q) begin
          snap_len_q <= b_rdata_i[15:0];
          snap_own_q <= b_rdata_i[16 + OWN_BIT];
          got_ctrl_q <= 1'b1;
        end else begin
          snap_base_q <= b_rdata_i;
          got_base_q  <= 1'b1;
        end
      end

      if (take) begin
        cnt_q  <= cnt_inc;
        oflo_q <= (accept ? 1'b0 : oflo_q) | ~fits;
        crc_q  <= (accept ? 1'b0 : crc_q)  | in_crc_err;
        fram_q <= (accept ? 1'b0 : fram_q) | in_frame_err;
        fifo_q <= (accept ? 1'b0 : fifo_q) | in_fifo_err;
      end

      unique case (state_q)
        ST_POLL: begin
          if (accept) begin
            base_q  <= snap_base_q;
            size_q  <= cur_size;
            len_q   <= snap_len_q;
            state_q <= in_last ? ST_WB_LEN : ST_RECV;
          end else if (start) begin
            miss_q  <= miss_q + MISS_ONE;
            state_q <= in_last ? ST_POLL : ST_DROP;
          end
        end
        ST_RECV: begin
          if (in_valid && in_last) state_q <= ST_WB_LEN;
        end
        ST_DROP: begin
          if (in_valid && in_last) state_q <= ST_POLL;
        end
        ST_WB_LEN: state_q <= ST_WB_STAT;
        ST_WB_STAT: begin
          state_q    <= ST_POLL;
          idx_q      <= idx_q + IDX_ONE;
          got_base_q <= 1'b0;
          got_ctrl_q <= 1'b0;
        end
        default: state_q <= ST_POLL;
      endcase
    end
  end

  // R7
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !accept) |=> (miss_q == $past(miss_q) + MISS_ONE));

  // R8
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB_STAT) |=> (idx_q == $past(idx_q) + IDX_ONE));

  // R3
  wb_order_chk: assert property (@(posedge clk) disable iff (rst)
    (b_we_o && b_addr_o[1:0] == W_CTRL) |-> $past(b_we_o && b_addr_o[1:0] == W_MLEN));

  // R5
  oflo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECV && oflo_q) |=> oflo_q);

  // R10
  gap_ok_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (state_q != ST_WB_LEN && state_q != ST_WB_STAT));

endmodule

// File: rtl/rxr_top.sv
module rxr_top
  import rxr_pkg::*;
#(
  parameter int LOG_RING = 2,
  parameter int MISS_W   = 8,
  parameter int MLEN_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  input  logic                 in_crc_err,
  input  logic                 in_frame_err,
  input  logic                 in_fifo_err,
  input  logic                 host_we,
  input  logic [LOG_RING+1:0]  host_addr,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  output logic                 buf_we,
  output logic [31:0]          buf_addr,
  output logic [7:0]           buf_data,
  output logic [MISS_W-1:0]    miss_count
);
  localparam int AW = LOG_RING + 2;

  logic          b_we;
  logic [AW-1:0] b_addr;
  logic [31:0]   b_wdata, b_rdata;
  logic          st_req;
  logic [31:0]   st_base;
  logic [15:0]   st_off;
  logic [7:0]    st_data;

  rxr_desc_ram #(.AW(AW), .DW(DESC_DW)) u_ram (
    .clk     (clk),
    .a_we    (host_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (host_rdata),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  rxr_ctrl #(.LOG_RING(LOG_RING), .MISS_W(MISS_W), .MLEN_W(MLEN_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_crc_err   (in_crc_err),
    .in_frame_err (in_frame_err),
    .in_fifo_err  (in_fifo_err),
    .b_we_o       (b_we),
    .b_addr_o     (b_addr),
    .b_wdata_o    (b_wdata),
    .b_rdata_i    (b_rdata),
    .st_req_o     (st_req),
    .st_base_o    (st_base),
    .st_off_o     (st_off),
    .st_data_o    (st_data),
    .miss_o       (miss_count)
  );

  rxr_byte_store #(.BA_W(DESC_DW), .OFF_W(16)) u_store (
    .clk        (clk),
    .rst        (rst),
    .req_i      (st_req),
    .base_i     (st_base),
    .off_i      (st_off),
    .data_i     (st_data),
    .buf_we_o   (buf_we),
    .buf_addr_o (buf_addr),
    .buf_data_o (buf_data)
  );
endmodule

// File: tb/rxr_top_tb.sv
module rxr_top_tb;
  localparam int LOG_RING = 2;
  localparam int NDESC = 1 << LOG_RING;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_crc_err = 1'b0, in_frame_err = 1'b0, in_fifo_err = 1'b0;
  logic host_we = 1'b0;
  logic [LOG_RING+1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic buf_we;
  logic [31:0] buf_addr;
  logic [7:0] buf_data;
  logic [7:0] miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] wa_q[$];
  logic [7:0]  wd_q[$];

  always #5 clk = ~clk;

  rxr_top #(.LOG_RING(LOG_RING)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_frame_err(in_frame_err), .in_fifo_err(in_fifo_err),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .miss_count(miss_count)
  );

  always @(negedge clk) begin
    if (!rst && buf_we) begin
      wa_q.push_back(buf_addr);
      wd_q.push_back(buf_data);
    end
  end

  function automatic logic [31:0] base_of(int i);
    return 32'h0001_0000 * (i + 1);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = (LOG_RING+2)'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = (LOG_RING+2)'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic arm(int i, int size);
    host_write(4*i + 1, {16'h8000, 16'(-size)});
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(int n, logic [7:0] seed, logic crc, logic fram, logic fifo);
    wa_q.delete(); wd_q.delete();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = seed + 8'(k);
      in_last = (k == n - 1);
      in_crc_err = crc && (k == n - 1);
      in_frame_err = fram && (k == n / 2);
      in_fifo_err = fifo && (k == 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    in_crc_err = 1'b0; in_frame_err = 1'b0; in_fifo_err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_stored(string req, int nstored, logic [31:0] base, logic [7:0] seed);
    check(req, "buffer write count", 32'(wa_q.size()), 32'(nstored));
    if (wa_q.size() == nstored) begin
      for (int k = 0; k < nstored; k++) begin
        if (wa_q[k] !== base + 32'(k) || wd_q[k] !== seed + 8'(k)) begin
          check(req, "buffer write address", wa_q[k], base + 32'(k));
          check(req, "buffer write data", 32'(wd_q[k]), 32'(seed + 8'(k)));
        end
      end
      checks++;
    end
  endtask

  task automatic check_desc(string req, int i, logic [31:0] w1, logic [31:0] w2);
    logic [31:0] d;
    host_read(4*i + 1, d);
    check(req, "status/length word", d, w1);
    host_read(4*i + 2, d);
    check(req, "message length word", d, w2);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "miss_count after reset", 32'(miss_count), 32'd0);
    check("R1", "buf_we after reset", 32'(buf_we), 32'd0);
    for (int i = 0; i < NDESC; i++) begin
      host_write(4*i + 0, base_of(i));
      host_write(4*i + 2, 32'hFFFF_FFFF);
      host_write(4*i + 3, 32'hC0DE_0000 | 32'(i));
      host_write(4*i + 1, {16'h8000, 16'(-((i == 3) ? 16 : 100))});
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clean();
    send_frame(64, 8'h10, 1'b0, 1'b0, 1'b0);
    check_stored("R2", 64, base_of(0), 8'h10);
    check_desc("R3", 0, {16'h0300, 16'(-100)}, 32'd64);
  endtask

  task automatic t_crc();
    send_frame(70, 8'h80, 1'b1, 1'b0, 1'b0);
    check_stored("R2", 70, base_of(1), 8'h80);
    check_desc("R6", 1, {16'h0B00, 16'(-100)}, 32'd70);
  endtask

  task automatic t_fram_fifo();
    send_frame(60, 8'hF0, 1'b0, 1'b1, 1'b1);
    check_stored("R6", 60, base_of(2), 8'hF0);
    check_desc("R4", 2, {16'h2700, 16'(-100)}, 32'd60);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    send_frame(20, 8'h40, 1'b0, 1'b0, 1'b0);
    check_stored("R5", 16, base_of(3), 8'h40);
    check_desc("R5", 3, {16'h1300, 16'(-16)}, 32'd20);
    host_read(4*3 + 0, d);
    check("R9", "base word untouched", d, base_of(3));
    host_read(4*3 + 3, d);
    check("R9", "reserved word untouched", d, 32'hC0DE_0003);
  endtask

  task automatic t_drop();
    send_frame(30, 8'h22, 1'b0, 1'b0, 1'b0);
    check("R7", "writes on dropped frame", 32'(wa_q.size()), 32'd0);
    check("R7", "miss_count after drop", 32'(miss_count), 32'd1);
    check_desc("R7", 0, {16'h0300, 16'(-100)}, 32'd64);
  endtask

  task automatic t_wrap_single();
    arm(0, 100);
    send_frame(1, 8'h77, 1'b0, 1'b0, 1'b0);
    check_stored("R8", 1, base_of(0), 8'h77);
    check_desc("R10", 0, {16'h0300, 16'(-100)}, 32'd1);
    check("R8", "miss_count unchanged", 32'(miss_count), 32'd1);
  endtask

  task automatic t_drop_next();
    send_frame(5, 8'h01, 1'b0, 1'b0, 1'b0);
    check("R7", "writes on second drop", 32'(wa_q.size()), 32'd0);
    check("R7", "miss_count second drop", 32'(miss_count), 32'd2);
    check_desc("R7", 1, {16'h0B00, 16'(-100)}, 32'd70);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_crc();
    t_fram_fifo();
    t_overflow();
    t_drop();
    t_wrap_single();
    t_drop_next();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule